// File: doc/BRIEF.md
# Clock Activity Detector with Output Gating

This block watches a monitored clock from the side of a free-running reference clock and decides whether the monitored clock toggles fast enough to count as alive. Each toggle of the monitored clock passes through a synchronizer into the reference domain. Rising edges are then counted over a fixed window of reference cycles. At the end of each window the count is compared with two thresholds. Both thresholds are worked out from parameters: the reference frequency, the window length, the activity frequency (20 MHz by default) and the lowest frequency for full operation (95 MHz by default).

While no activity is seen, the block sits in a low-power state: the gated outputs are disabled and the low-power flag is raised. The first active window starts a settling period of a fixed length in time (100 us by default, converted to reference cycles). Only when that period ends are the lock status and the output enable raised. Any window without enough activity shuts everything down on the next cycle, whatever state the block is in. The next detection then restarts settling from zero. A separate flag marks a clock that is active but slower than the full-operation frequency.

Top module: `clk_activity_gate`

## Requirements
- R1: Each rising edge of `mon_clk` (high and low phases each at least one reference cycle long) is counted once, after a synchronizer of `SYNC_STAGES` reference flops. Counts are taken over consecutive windows of `WIN_CYCLES` reference cycles.
- R2: A window is active when its count is at least ACT = ceil(ACT_KHZ*WIN_CYCLES/REF_KHZ). A clock that gives fewer edges per window never leaves the low-power state.
- R3: When the first active window ends in the low-power state, `low_power` drops on the next cycle. `locked` and `out_en` rise exactly STAB = ceil(SETTLE_NS*REF_KHZ/1e6) reference cycles after `low_power` drops.
- R4: On the cycle after any inactive window ends, `locked`=0, `out_en`=0, `low_power`=1 and `below_spec`=0. This also holds when the window ends in the same cycle as the settling period would expire, so lock is never shown.
- R5: `low_power` is 1 exactly while the block is neither settling nor locked.
- R6: At the end of each active window, `below_spec` is set to (count < SPEC), where SPEC = ceil(SPEC_KHZ*WIN_CYCLES/REF_KHZ). It holds that value until the next window ends, and it is 0 whenever `low_power` is 1.
- R7: During reset, `locked`=0, `out_en`=0, `low_power`=1 and `below_spec`=0.
- R8: After a loss of activity, the next detection restarts settling from zero, and lock again needs the full STAB cycles.
- R9: Once locked, further active windows keep `locked` and `out_en` high, including windows that set `below_spec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_clk | input | 1 | Monitored clock, asynchronous to `clk` |
| out_en | output | 1 | Enable for the downstream gated clock outputs |
| locked | output | 1 | Settling finished and activity present |
| low_power | output | 1 | No activity: outputs disabled, receivers powered down |
| below_spec | output | 1 | Active, but slower than the full-operation frequency |

## Verification
Two events can land on the same reference cycle: the settling timer reaching its end and the close of a window whose edge count is below the activity threshold. The bench provokes this by starting a fast monitored clock and waiting for `low_power` to fall. With a settling length that is a whole number of windows, it then stops the monitored clock 40 cycles before expiry. As a result the last window before expiry holds no edges. The expected outcome is that shutdown wins: `locked` never rises, and `low_power` returns to 1 on the cycle after that window closes, in step with the bench's own model.

// File: rtl/cad_pkg.sv
package cad_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_LOCK   = 2'd2
  } cad_state_e;

  // Edges a window must hold for a clock of khz: ceil(khz*win/ref_khz)
  function automatic int unsigned edges_needed(longint unsigned khz,
                                               longint unsigned win,
                                               longint unsigned ref_khz);
    return 32'((khz * win + ref_khz - 1) / ref_khz);
  endfunction

  // Reference cycles spanning ns nanoseconds, rounded up
  function automatic int unsigned settle_cycles(longint unsigned ns,
                                                longint unsigned ref_khz);
    return 32'((ns * ref_khz + 64'd999999) / 64'd1000000);
  endfunction

endpackage

// File: rtl/cad_edge_sync.sv
module cad_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SH_W-2:0], async_in};
  end

  assign rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];

  // Two rising edges cannot be seen on back-to-back reference cycles
  assert_rise_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/cad_window_counter.sv
module cad_window_counter #(
  parameter int WIN_CYCLES = 256,
  parameter int CNT_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  output logic             win_done,
  output logic [CNT_W-1:0] win_cnt
);
  localparam int TICK_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam int MAX_EDGES = (WIN_CYCLES + 1) / 2;

  logic [TICK_W-1:0] tick;
  logic [CNT_W-1:0]  run_cnt;
  logic              win_last;

  assign win_last = (tick == TICK_W'(WIN_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick     <= '0;
      run_cnt  <= '0;
      win_cnt  <= '0;
      win_done <= 1'b0;
    end else if (win_last) begin
      tick     <= '0;
      run_cnt  <= '0;
      win_cnt  <= run_cnt + CNT_W'(rise);
      win_done <= 1'b1;
    end else begin
      tick     <= tick + 1'b1;
      run_cnt  <= run_cnt + CNT_W'(rise);
      win_done <= 1'b0;
    end
  end

  assert_window_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |-> (win_cnt <= CNT_W'(MAX_EDGES)));

  assert_window_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> !win_done);

endmodule

// File: rtl/cad_lock_fsm.sv
module cad_lock_fsm
  import cad_pkg::*;
#(
  parameter int ACT_EDGES   = 21,
  parameter int SPEC_EDGES  = 98,
  parameter int STAB_CYCLES = 25000,
  parameter int CNT_W       = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_done,
  input  logic [CNT_W-1:0] win_cnt,
  output cad_state_e       state,
  output logic             below_spec
);
  localparam int TMR_W = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
  localparam int AGE_W = $clog2(STAB_CYCLES + 1);

  logic [TMR_W-1:0] timer;
  logic win_idle;
  logic win_live;
  logic settle_end;

  assign win_idle   = win_done && (win_cnt < CNT_W'(ACT_EDGES));
  assign win_live   = win_done && !win_idle;
  assign settle_end = (state == ST_SETTLE) && (timer == TMR_W'(STAB_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      timer      <= '0;
      below_spec <= 1'b0;
    end else if (win_idle) begin
      state      <= ST_IDLE;
      timer      <= '0;
      below_spec <= 1'b0;
    end else begin
      if (win_live) below_spec <= (win_cnt < CNT_W'(SPEC_EDGES));
      case (state)
        ST_IDLE: if (win_live) begin
          state <= ST_SETTLE;
          timer <= '0;
        end
        ST_SETTLE: if (settle_end) begin
          state <= ST_LOCK;
          timer <= '0;
        end else begin
          timer <= timer + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // Checker: cycles spent settling since entry
  logic [AGE_W-1:0] settle_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   settle_age <= '0;
    else if (state != ST_SETTLE)  settle_age <= '0;
    else if (settle_age != AGE_W'(STAB_CYCLES)) settle_age <= settle_age + 1'b1;
  end

  assert_idle_shutdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
    win_idle |=> (state == ST_IDLE) && !below_spec);

  assert_wake_on_activity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && win_live) |=> (state == ST_SETTLE));

  assert_full_settle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOCK && $past(state) != ST_LOCK) |-> (settle_age == AGE_W'(STAB_CYCLES)));

  assert_below_needs_activity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    below_spec |-> (state != ST_IDLE));

  assert_lock_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOCK && win_live) |=> (state == ST_LOCK));

endmodule

// File: rtl/clk_activity_gate.sv
module clk_activity_gate
  import cad_pkg::*;
#(
  parameter int REF_KHZ     = 250000,
  parameter int WIN_CYCLES  = 256,
  parameter int ACT_KHZ     = 20000,
  parameter int SPEC_KHZ    = 95000,
  parameter int SETTLE_NS   = 100000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_clk,
  output logic out_en,
  output logic locked,
  output logic low_power,
  output logic below_spec
);
  localparam int CNT_W       = $clog2(WIN_CYCLES + 1);
  localparam int ACT_EDGES   = int'(edges_needed(ACT_KHZ, WIN_CYCLES, REF_KHZ));
  localparam int SPEC_EDGES  = int'(edges_needed(SPEC_KHZ, WIN_CYCLES, REF_KHZ));
  localparam int STAB_CYCLES = int'(settle_cycles(SETTLE_NS, REF_KHZ));

  logic             mon_rise;
  logic             win_done;
  logic [CNT_W-1:0] win_cnt;
  cad_state_e       state;

  cad_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(mon_clk), .rise(mon_rise)
  );

  cad_window_counter #(.WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W)) u_win (
    .clk(clk), .rst_n(rst_n), .rise(mon_rise),
    .win_done(win_done), .win_cnt(win_cnt)
  );

  cad_lock_fsm #(
    .ACT_EDGES(ACT_EDGES), .SPEC_EDGES(SPEC_EDGES),
    .STAB_CYCLES(STAB_CYCLES), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .win_done(win_done), .win_cnt(win_cnt),
    .state(state), .below_spec(below_spec)
  );

  assign locked    = (state == ST_LOCK);
  assign out_en    = (state == ST_LOCK);
  assign low_power = (state == ST_IDLE);

  assert_quiet_stays_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (low_power && !win_done) |=> low_power);

endmodule

// File: tb/sim_clk_activity_gate.sv
module sim_clk_activity_gate;
  localparam int REF_KHZ = 250000;
  localparam int WIN     = 32;
  localparam int SET_NS  = 1024;
  // Thresholds restated from the requirements
  localparam int ACT  = (20000 * WIN + REF_KHZ - 1) / REF_KHZ;   // 3
  localparam int SPEC = (95000 * WIN + REF_KHZ - 1) / REF_KHZ;   // 13
  localparam int STAB = 256;                                     // 1024 ns at 4 ns

  logic clk = 0, rst_n = 0, mon = 0;
  logic out_en, locked, low_power, below_spec;
  int total = 0, bad = 0, cyc = 0, half = 0, hc = 0;
  bit finished = 0;

  clk_activity_gate #(.REF_KHZ(REF_KHZ), .WIN_CYCLES(WIN), .SETTLE_NS(SET_NS)) u0 (
    .clk(clk), .rst_n(rst_n), .mon_clk(mon), .out_en(out_en),
    .locked(locked), .low_power(low_power), .below_spec(below_spec)
  );

  always #2 clk = ~clk;

  // Monitored clock: half period in reference cycles, 0 = stopped low
  always @(negedge clk) begin
    if (half == 0) begin mon <= 0; hc <= 0; end
    else if (hc >= half - 1) begin mon <= ~mon; hc <= 0; end
    else hc <= hc + 1;
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference model
  int mq[$];
  int m_tick, m_cnt, m_wc, m_st, m_tmr;
  bit m_wd, m_below;
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mq = '{0, 0, 0};
      m_tick = 0; m_cnt = 0; m_wc = 0; m_wd = 0; m_st = 0; m_tmr = 0; m_below = 0;
    end else begin : mstep
      int e, owc;
      bit owd;
      owd = m_wd; owc = m_wc;
      if (owd && owc < ACT) begin m_st = 0; m_tmr = 0; m_below = 0; end
      else begin
        if (m_st == 1) begin
          if (m_tmr == STAB - 1) begin m_st = 2; m_tmr = 0; end else m_tmr++;
        end
        if (owd) begin
          m_below = (owc < SPEC);
          if (m_st == 0) begin m_st = 1; m_tmr = 0; end
        end
      end
      // mq[0] newest sample; edge seen two samples back
      e = (mq[1] == 1 && mq[2] == 0) ? 1 : 0;
      if (m_tick == WIN - 1) begin m_wc = m_cnt + e; m_wd = 1; m_cnt = 0; m_tick = 0; end
      else begin m_cnt += e; m_tick++; m_wd = 0; end
      mq.push_front(int'(mon));
      void'(mq.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R3 R4 R9 locked vs model",     int'(locked),     (m_st == 2) ? 1 : 0);
      check("R3 R4 out_en vs model",        int'(out_en),     (m_st == 2) ? 1 : 0);
      check("R1 R2 R5 low_power vs model",  int'(low_power),  (m_st == 0) ? 1 : 0);
      check("R6 below_spec vs model",       int'(below_spec), int'(m_below));
    end
  end

  always @(posedge clk) begin
    if (cyc > 30000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=30000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic settle_time(string tag);
    int t0, g;
    g = 0;
    while (low_power && g < 2000) begin @(negedge clk); g++; end
    t0 = cyc; g = 0;
    while (!locked && g < 2000) begin @(negedge clk); g++; end
    check(tag, cyc - t0, STAB);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset locked", int'(locked), 0);
    check("R7 reset out_en", int'(out_en), 0);
    check("R7 reset low_power", int'(low_power), 1);
    check("R7 reset below_spec", int'(below_spec), 0);
    rst_n = 1;

    // Fast clock: detect, settle, lock
    half = 1;
    settle_time("R3 settle length");
    repeat (40) @(negedge clk);
    check("R3 locked", int'(locked), 1);
    check("R3 out_en", int'(out_en), 1);
    check("R6 fast not below", int'(below_spec), 0);

    // Active but slow: flagged, lock kept
    half = 2;
    repeat (100) @(negedge clk);
    check("R6 slow flagged", int'(below_spec), 1);
    check("R9 lock kept", int'(locked), 1);

    // Stop: immediate shutdown
    half = 0;
    repeat (80) @(negedge clk);
    check("R4 locked dropped", int'(locked), 0);
    check("R4 out_en dropped", int'(out_en), 0);
    check("R5 low_power", int'(low_power), 1);
    check("R4 below cleared", int'(below_spec), 0);

    // Collision: inactive window ends as settling expires
    half = 1;
    begin : coll
      int g; bit seen;
      g = 0; seen = 0;
      while (low_power && g < 2000) begin @(negedge clk); g++; end
      repeat (STAB - 40) @(negedge clk);
      half = 0;
      repeat (80) begin @(negedge clk); if (locked) seen = 1; end
      check("R4 collision no lock", int'(seen), 0);
      check("R4 collision low_power", int'(low_power), 1);
    end

    // Slowest active rate: full restart of settling
    half = 5;
    settle_time("R8 restart settle length");
    check("R2 boundary active locked", int'(locked), 1);

    // Just below activity threshold
    half = 8;
    repeat (120) @(negedge clk);
    check("R2 below threshold low_power", int'(low_power), 1);
    begin : quiet
      bit seen;
      seen = 0;
      repeat (300) begin @(negedge clk); if (!low_power || locked) seen = 1; end
      check("R2 slow clock stays idle", int'(seen), 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule